// File: doc/BRIEF.md
# Linked-Descriptor Copy Channel

This block is a single copy channel driven by a chain of descriptors kept in memory. Software loads the byte address of the first descriptor into the descriptor-pointer register. It then raises the run bit in the control register. The channel reads the four-word descriptor and copies the data one 32-bit word at a time through a valid/ready memory port. It then follows the next-link word to the following descriptor. The chain stops after a descriptor whose next-link word carries the last-link flag.

Each event is recorded in a sticky status register that software clears by writing ones. The recorded events are a finished descriptor, a finished chain, a zero byte count and an error response from memory. An interrupt line combines these events under two enable bits. A stop strobe in the control register ends a run at once and leaves the channel in a halted state. A snoop attribute bit travels with the descriptor pointer and is driven out during descriptor reads. It is never used as an address bit.

Register map (2-bit word index): 0 control, 1 status, 2 descriptor pointer, 3 remaining byte count.

Top module: `ldc_chan`

## Requirements
- R1: After reset, control, status, descriptor pointer and remaining count all read zero, `irq_o` is low and `mem_req_o` is low.
- R2: A descriptor is four words at base, base+4, base+8 and base+12: source address, destination address, next-link word and byte count. The base is the descriptor pointer with its low five bits forced to zero.
- R3: Each descriptor copies count/4 words in ascending order. Every word is read from source+4k and then written to destination+4k. Nothing beyond the last word is written, and the count register reads zero at the end.
- R4: Bit 1 of a next-link word is the last-link flag. Status bit 1 is set after every completed descriptor. Status bit 0 is set when the chain ends after the flagged descriptor.
- R5: Control bit 0 is the run bit. A run begins only when a write takes this bit from 0 to 1 while the channel is not busy. Hardware never clears the bit, so writing 1 again while it is already 1 starts nothing.
- R6: Status bit 4 (busy) is set while a run is active. Status bit 5 (halted) is set by a stop. No memory request is made while the channel is not busy.
- R7: Status event bits 0 to 3 are cleared by writing 1 to them. Writing 0 leaves them unchanged.
- R8: A descriptor with a zero count sets status bit 2 and ends the run without any data traffic. The count register then reads zero.
- R9: An error response from memory sets status bit 3 and ends the run. Writes already completed remain, and no later word is written.
- R10: Writing 1 to control bit 1 while busy stops the run on the next edge. Busy clears and halted sets. The next run start clears halted.
- R11: `irq_o` is high exactly when (control bit 2 and status bit 2 or 3) or (control bit 3 and status bit 0).
- R12: The descriptor pointer always holds the descriptor in use. At the end of a chain it reads the last descriptor, including bit 0, the snoop attribute. Bit 0 is driven on `mem_snoop_o` during descriptor reads and is not part of the address.
- R13: Once `mem_req_o` is raised, the request and its address hold until `mem_ready_i` accepts it, unless a stop intervenes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | ADDR_W | Byte address of the word |
| mem_wdata_o | output | 32 | Write data |
| mem_snoop_o | output | 1 | Snoop attribute of the descriptor being read |
| mem_ready_i | input | 1 | Request accepted; read data and error are valid in this cycle |
| mem_rdata_i | input | 32 | Read data |
| mem_err_i | input | 1 | Error response for the accepted request |
| irq_o | output | 1 | Interrupt |

## Verification
The bench runs single-word, odd-length and multi-word descriptors, and checks that the word just past each destination still holds a sentinel. An engine off by one word would overrun that guard. A two-descriptor chain runs with a stalling memory. This checks that a snoop bit in the next-link word does not shift the fetch address and that the pointer ends on the last descriptor. It also catches dropped requests under back-pressure.

Further directed cases cover a zero count, an error on the second write, a stop halfway through a long copy, and a repeated run-bit write. Each one shows up as wrong status bits, a wrong interrupt level, or memory being written when it should be left alone.

// File: rtl/ldc_pkg.sv
package ldc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_CHECK, ST_RD, ST_WR, ST_DONE
  } ldc_state_e;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_STAT = 2'd1;
  localparam logic [1:0] REG_DPTR = 2'd2;
  localparam logic [1:0] REG_CNT  = 2'd3;

  localparam int CTL_RUN    = 0;
  localparam int CTL_STOP   = 1;
  localparam int CTL_ERR_IE = 2;
  localparam int CTL_END_IE = 3;
  localparam int CTL_W      = 4;

  localparam int EV_END  = 0;
  localparam int EV_SEG  = 1;
  localparam int EV_ZERO = 2;
  localparam int EV_BUS  = 3;
  localparam int EV_N    = 4;

  localparam int LINK_SNOOP = 0;
  localparam int LINK_LAST  = 1;
  localparam int DESC_ALIGN = 5;
endpackage

// File: rtl/ldc_regs.sv
module ldc_regs
  import ldc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              busy_i,
  input  logic              halted_i,
  input  logic [EV_N-1:0]   evt_set_i,
  input  logic [ADDR_W-1:0] dptr_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              go_o,
  output logic              stop_o,
  output logic              dptr_we_o,
  output logic              cnt_we_o,
  output logic              irq_o
);
  logic [CTL_W-1:0] ctl_q;
  logic [EV_N-1:0]  evt_q;
  logic             wr_ctl, wr_stat;

  assign wr_ctl  = reg_we_i && (reg_addr_i == REG_CTRL);
  assign wr_stat = reg_we_i && (reg_addr_i == REG_STAT);

  assign go_o      = wr_ctl && reg_wdata_i[CTL_RUN] && !ctl_q[CTL_RUN] && !busy_i;
  assign stop_o    = wr_ctl && reg_wdata_i[CTL_STOP];
  assign dptr_we_o = reg_we_i && (reg_addr_i == REG_DPTR) && !busy_i;
  assign cnt_we_o  = reg_we_i && (reg_addr_i == REG_CNT) && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
    end else if (wr_ctl) begin
      ctl_q <= reg_wdata_i[CTL_W-1:0];
      ctl_q[CTL_STOP] <= 1'b0;
    end
  end

  for (genvar g = 0; g < EV_N; g++) begin : g_evt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            evt_q[g] <= 1'b0;
      else if (evt_set_i[g])  evt_q[g] <= 1'b1;
      else if (wr_stat && reg_wdata_i[g]) evt_q[g] <= 1'b0;
    end

    p_w1c_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_stat && reg_wdata_i[g] && !evt_set_i[g]) |=> !evt_q[g]);
  end

  assign irq_o = (ctl_q[CTL_ERR_IE] && (evt_q[EV_ZERO] || evt_q[EV_BUS]))
              || (ctl_q[CTL_END_IE] && evt_q[EV_END]);

  always_comb begin
    unique case (reg_addr_i)
      REG_CTRL: reg_rdata_o = 32'(ctl_q);
      REG_STAT: reg_rdata_o = {26'd0, halted_i, busy_i, evt_q};
      REG_DPTR: reg_rdata_o = 32'(dptr_i);
      default:  reg_rdata_o = 32'(cnt_i);
    endcase
  end

  p_irq_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_q == '0) |-> !irq_o);
endmodule

// File: rtl/ldc_engine.sv
module ldc_engine
  import ldc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic              stop_i,
  input  logic              dptr_we_i,
  input  logic              cnt_we_i,
  input  logic [31:0]       sw_wdata_i,
  output logic [ADDR_W-1:0] dptr_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              busy_o,
  output logic              halted_o,
  output logic [EV_N-1:0]   evt_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  output logic              mem_snoop_o,
  input  logic              mem_ready_i,
  input  logic [31:0]       mem_rdata_i,
  input  logic              mem_err_i
);
  localparam int HI_W = ADDR_W - DESC_ALIGN;

  ldc_state_e        state_q;
  logic [1:0]        idx_q;
  logic [ADDR_W-1:0] src_q, dst_q, dptr_q;
  logic [HI_W-1:0]   nxt_hi_q;
  logic              nxt_last_q, nxt_snp_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [31:0]       data_q;
  logic              halted_q;
  logic [EV_N-1:0]   evt_q;
  logic              accept, fail;

  assign accept = mem_req_o && mem_ready_i;
  assign fail   = accept && mem_err_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      idx_q      <= '0;
      src_q      <= '0;
      dst_q      <= '0;
      dptr_q     <= '0;
      nxt_hi_q   <= '0;
      nxt_last_q <= 1'b0;
      nxt_snp_q  <= 1'b0;
      cnt_q      <= '0;
      data_q     <= '0;
      halted_q   <= 1'b0;
      evt_q      <= '0;
    end else begin
      evt_q <= '0;
      unique case (state_q)
        ST_IDLE: begin
          if (dptr_we_i)
            dptr_q <= {sw_wdata_i[ADDR_W-1:DESC_ALIGN], 4'd0, sw_wdata_i[LINK_SNOOP]};
          if (cnt_we_i) cnt_q <= sw_wdata_i[CNT_W-1:0];
          if (go_i) begin
            state_q  <= ST_FETCH;
            idx_q    <= '0;
            halted_q <= 1'b0;
          end
        end
        ST_FETCH: begin
          if (fail) begin
            evt_q[EV_BUS] <= 1'b1;
            state_q       <= ST_IDLE;
          end else if (accept) begin
            unique case (idx_q)
              2'd0: src_q <= mem_rdata_i[ADDR_W-1:0];
              2'd1: dst_q <= mem_rdata_i[ADDR_W-1:0];
              2'd2: begin
                nxt_hi_q   <= mem_rdata_i[ADDR_W-1:DESC_ALIGN];
                nxt_last_q <= mem_rdata_i[LINK_LAST];
                nxt_snp_q  <= mem_rdata_i[LINK_SNOOP];
              end
              default: cnt_q <= mem_rdata_i[CNT_W-1:0];
            endcase
            if (idx_q == 2'd3) state_q <= ST_CHECK;
            idx_q <= idx_q + 2'd1;
          end
        end
        ST_CHECK: begin
          if (cnt_q == '0) begin
            evt_q[EV_ZERO] <= 1'b1;
            state_q        <= ST_IDLE;
          end else begin
            state_q <= ST_RD;
          end
        end
        ST_RD: begin
          if (fail) begin
            evt_q[EV_BUS] <= 1'b1;
            state_q       <= ST_IDLE;
          end else if (accept) begin
            data_q  <= mem_rdata_i;
            state_q <= ST_WR;
          end
        end
        ST_WR: begin
          if (fail) begin
            evt_q[EV_BUS] <= 1'b1;
            state_q       <= ST_IDLE;
          end else if (accept) begin
            src_q <= src_q + ADDR_W'(4);
            dst_q <= dst_q + ADDR_W'(4);
            if (cnt_q <= CNT_W'(4)) begin
              cnt_q   <= '0;
              state_q <= ST_DONE;
            end else begin
              cnt_q   <= cnt_q - CNT_W'(4);
              state_q <= ST_RD;
            end
          end
        end
        ST_DONE: begin
          evt_q[EV_SEG] <= 1'b1;
          if (nxt_last_q) begin
            evt_q[EV_END] <= 1'b1;
            state_q       <= ST_IDLE;
          end else begin
            dptr_q  <= {nxt_hi_q, 4'd0, nxt_snp_q};
            idx_q   <= '0;
            state_q <= ST_FETCH;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
      if (stop_i && state_q != ST_IDLE) begin
        state_q  <= ST_IDLE;
        halted_q <= 1'b1;
        evt_q    <= '0;
      end
    end
  end

  always_comb begin
    mem_req_o   = (state_q == ST_FETCH) || (state_q == ST_RD) || (state_q == ST_WR);
    mem_we_o    = (state_q == ST_WR);
    mem_wdata_o = data_q;
    mem_snoop_o = (state_q == ST_FETCH) && dptr_q[LINK_SNOOP];
    unique case (state_q)
      ST_FETCH: mem_addr_o = {dptr_q[ADDR_W-1:DESC_ALIGN], 1'b0, idx_q, 2'b00};
      ST_WR:    mem_addr_o = dst_q;
      default:  mem_addr_o = src_q;
    endcase
  end

  assign dptr_o   = dptr_q;
  assign cnt_o    = cnt_q;
  assign busy_o   = (state_q != ST_IDLE);
  assign halted_o = halted_q;
  assign evt_o    = evt_q;

  p_req_hold_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i && !stop_i) |=> (mem_req_o && $stable(mem_addr_o)));
  p_zero_ends_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o[EV_ZERO] |-> (!busy_o && cnt_o == '0));
  p_err_ends_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o[EV_BUS] |-> !mem_req_o);
  p_stop_halts_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && busy_o) |=> (!busy_o && halted_o));
endmodule

// File: rtl/ldc_chan.sv
module ldc_chan
  import ldc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  output logic              mem_snoop_o,
  input  logic              mem_ready_i,
  input  logic [31:0]       mem_rdata_i,
  input  logic              mem_err_i,
  output logic              irq_o
);
  logic              go, stop, dptr_we, cnt_we, busy, halted;
  logic [EV_N-1:0]   evt;
  logic [ADDR_W-1:0] dptr;
  logic [CNT_W-1:0]  cnt;

  ldc_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .busy_i(busy), .halted_i(halted), .evt_set_i(evt), .dptr_i(dptr), .cnt_i(cnt),
    .go_o(go), .stop_o(stop), .dptr_we_o(dptr_we), .cnt_we_o(cnt_we), .irq_o
  );

  ldc_engine #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_engine (
    .clk_i, .rst_ni, .go_i(go), .stop_i(stop), .dptr_we_i(dptr_we), .cnt_we_i(cnt_we),
    .sw_wdata_i(reg_wdata_i), .dptr_o(dptr), .cnt_o(cnt), .busy_o(busy),
    .halted_o(halted), .evt_o(evt), .mem_req_o, .mem_we_o, .mem_addr_o,
    .mem_wdata_o, .mem_snoop_o, .mem_ready_i, .mem_rdata_i, .mem_err_i
  );

  p_idle_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !mem_req_o);
endmodule

// File: tb/ldc_chan_test.sv
module ldc_chan_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we, mem_snoop, mem_ready, mem_err, irq;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  logic [31:0] mem [0:255];
  logic        host_we = 1'b0;
  logic [7:0]  host_idx = '0;
  logic [31:0] host_data = '0;
  logic        stall_en = 1'b0;
  logic        err_en = 1'b0;
  logic [31:0] err_addr = '0;
  int unsigned cyc = 0;
  int          total = 0;
  int          fails = 0;

  always #2 clk = ~clk;

  ldc_chan uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .mem_req_o(mem_req),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_snoop_o(mem_snoop), .mem_ready_i(mem_ready), .mem_rdata_i(mem_rdata),
    .mem_err_i(mem_err), .irq_o(irq)
  );

  assign mem_ready = stall_en ? cyc[0] : 1'b1;
  assign mem_err   = err_en && mem_req && (mem_addr == err_addr);
  assign mem_rdata = mem[mem_addr[9:2]];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (host_we) mem[host_idx] <= host_data;
    else if (mem_req && mem_we && mem_ready && !mem_err) mem[mem_addr[9:2]] <= mem_wdata;
  end

  localparam logic [31:0] SENT = 32'hDEAD_BEEF;
  // descriptor base, source, destination, byte count
  localparam logic [31:0] VEC [0:3][0:3] = '{
    '{32'h000, 32'h100, 32'h200, 32'd4},
    '{32'h020, 32'h140, 32'h240, 32'd12},
    '{32'h040, 32'h104, 32'h280, 32'd32},
    '{32'h060, 32'h1C0, 32'h300, 32'd8}
  };

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {16'hC0DE, a[15:0]} ^ {a[7:0], 24'h0};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_idx = a[9:2]; host_data = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic put_desc(input logic [31:0] b, input logic [31:0] s, input logic [31:0] d,
                          input logic [31:0] n, input logic [31:0] c);
    poke(b, s); poke(b + 4, d); poke(b + 8, n); poke(b + 12, c);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 2000; i++) begin
      rd(2'd1, s);
      if (!s[4]) break;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic run(input logic [31:0] desc, input logic [31:0] ctl);
    wr(2'd0, 32'h0);
    wr(2'd2, desc);
    wr(2'd0, ctl);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual %0d expected done", cyc);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, r); chk("R1 ctrl", r, 0);
    rd(2'd1, r); chk("R1 status", r, 0);
    rd(2'd2, r); chk("R1 pointer", r, 0);
    rd(2'd3, r); chk("R1 count", r, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 req", {31'd0, mem_req}, 0);

    for (int i = 0; i < 256; i++)
      poke(i * 4, (i >= 64 && i < 128) ? pat(i * 4) : SENT);

    // R2 R3 R4 R12: table of single-descriptor copies, no interrupt enables
    for (int v = 0; v < 4; v++) begin
      put_desc(VEC[v][0], VEC[v][1], VEC[v][2], 32'h2, VEC[v][3]);
      run(VEC[v][0], 32'h1);
      wait_idle();
      for (int w = 0; w < int'(VEC[v][3] / 4); w++)
        chk("R3 copied word", mem[(VEC[v][2] >> 2) + w], pat(VEC[v][1] + 4 * w));
      chk("R3 guard word", mem[(VEC[v][2] + VEC[v][3]) >> 2], SENT);
      rd(2'd1, r); chk("R4 end+segment", r, 32'h3);
      rd(2'd3, r); chk("R3 count zero", r, 0);
      rd(2'd2, r); chk("R12 pointer", r, VEC[v][0]);
      chk("R11 irq masked", {31'd0, irq}, 0);
      if (v == 0) begin
        wr(2'd1, 32'h1);
        rd(2'd1, r); chk("R7 w1c partial", r, 32'h2);
      end
      wr(2'd1, 32'hF);
      rd(2'd1, r); chk("R7 cleared", r, 0);
    end

    // R5: run bit still set, rewriting 1 starts nothing
    wr(2'd0, 32'h1);
    repeat (20) @(negedge clk);
    rd(2'd1, r); chk("R5 no restart", r, 0);
    rd(2'd0, r); chk("R5 run bit kept", r, 32'h1);

    // R4 R12 R13: two-descriptor chain under stalls, snoop bit in link
    put_desc(32'h0C0, 32'h1A0, 32'h340, 32'h0E1, 32'd8);
    put_desc(32'h0E0, 32'h1B0, 32'h350, 32'h002, 32'd4);
    stall_en = 1'b1;
    run(32'h0C0, 32'h9);
    wait_idle();
    stall_en = 1'b0;
    chk("R4 chain w0", mem[32'h340 >> 2], pat(32'h1A0));
    chk("R13 chain w1", mem[32'h344 >> 2], pat(32'h1A4));
    chk("R4 chain second", mem[32'h350 >> 2], pat(32'h1B0));
    chk("R3 chain guard", mem[32'h348 >> 2], SENT);
    rd(2'd2, r); chk("R12 last pointer with snoop", r, 32'h0E1);
    rd(2'd1, r); chk("R4 chain status", r, 32'h3);
    chk("R11 end irq", {31'd0, irq}, 1);
    wr(2'd1, 32'h1);
    chk("R11 irq after clear", {31'd0, irq}, 0);
    wr(2'd1, 32'hF);

    // R8: zero count
    put_desc(32'h080, 32'h100, 32'h3E0, 32'h002, 32'd0);
    wr(2'd3, 32'h40);
    rd(2'd3, r); chk("R8 count written", r, 32'h40);
    run(32'h080, 32'h5);
    wait_idle();
    rd(2'd1, r); chk("R8 zero status", r, 32'h4);
    rd(2'd3, r); chk("R8 count zero", r, 0);
    chk("R8 no write", mem[32'h3E0 >> 2], SENT);
    chk("R11 zero irq", {31'd0, irq}, 1);
    wr(2'd1, 32'hF);

    // R9: error on second write
    put_desc(32'h0A0, 32'h110, 32'h3C0, 32'h002, 32'd8);
    err_en = 1'b1; err_addr = 32'h3C4;
    run(32'h0A0, 32'h5);
    wait_idle();
    err_en = 1'b0;
    rd(2'd1, r); chk("R9 error status", r, 32'h8);
    chk("R9 first word kept", mem[32'h3C0 >> 2], pat(32'h110));
    chk("R9 failed word", mem[32'h3C4 >> 2], SENT);
    chk("R11 error irq", {31'd0, irq}, 1);
    wr(2'd1, 32'h8);
    rd(2'd1, r); chk("R7 error cleared", r, 0);
    chk("R11 irq drops", {31'd0, irq}, 0);

    // R10: stop during a 16-word copy, then restart
    put_desc(32'h080, 32'h100, 32'h380, 32'h002, 32'd64);
    run(32'h080, 32'h1);
    repeat (10) @(negedge clk);
    wr(2'd0, 32'h2);
    rd(2'd1, r); chk("R10 halted not busy", r, 32'h20);
    chk("R10 tail untouched", mem[32'h3BC >> 2], SENT);
    chk("R6 no request", {31'd0, mem_req}, 0);
    wr(2'd0, 32'h1);
    rd(2'd1, r); chk("R10 halted cleared, R6 busy", r & 32'h30, 32'h10);
    wait_idle();
    chk("R10 restart tail", mem[32'h3BC >> 2], pat(32'h13C));
    rd(2'd1, r); chk("R6 idle after run", r, 32'h3);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule